// File: doc/BRIEF.md
# Stall-Tolerant Virtual Processor Clock Enable

This block turns a fast fabric clock into a slower virtual processor clock. The virtual clock is a stream of single-cycle enable pulses. With the defaults, a 100 MHz fabric clock gives an 8 MHz virtual clock. A phase accumulator adds `NUM` each fabric cycle and emits a pulse whenever it passes `DEN`. This makes the pulse spacing alternate between 12 and 13 fabric cycles, so the average rate is exact.

The emulated machine must see every memory access complete within one virtual cycle. While a memory request is pending and its data is not yet ready, the accumulator is frozen and no pulse goes out. Each frozen fabric cycle is added to a debt counter. Once the data arrives, the accumulator advances faster until the debt is cleared. In each catch-up cycle it advances by up to `BOOST + 1` steps, where `BOOST = DEN / (NUM * MIN_GAP) - 1`. This keeps pulses at least `MIN_GAP` fabric cycles apart, and the long-term pulse count still matches the nominal rate.

The debt counter saturates at `DEBT_MAX`. Stall cycles that arrive while it is full are lost, and a sticky flag records the loss.

Top module: `vclk_ce_gen`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `ce` is 0, `debt` is 0 and `debt_ovf` is 0.
- R2: With no stalls after reset, the first `ce` pulse is seen in the 13th fabric cycle after reset release (ceil(DEN/NUM) with the defaults).
- R3: With no stalls, the accumulator advances by `NUM` each cycle and `ce` pulses exactly when it reaches or passes `DEN`. This gives exactly 16 pulses in the first 200 cycles after reset with NUM=8 and DEN=100.
- R4: A cycle with `mem_req`=1 and `mem_rdy`=0 is a stall. The next cycle shows `ce`=0, and `debt` has grown by one unless it was already at `DEBT_MAX`.
- R5: The cycle in which `mem_rdy` is 1 together with `mem_req` is not a stall, so the accumulator advances in that same cycle.
- R6: In a non-stalled cycle with nonzero debt, `debt` drops by min(debt, BOOST) and the accumulator advances by `NUM*(1+repaid)`, so debt falls to zero.
- R7: Two `ce` pulses are never closer than `MIN_GAP` fabric cycles, even during catch-up.
- R8: `debt` never exceeds `DEBT_MAX`. A stall cycle that finds `debt` at `DEBT_MAX` sets `debt_ovf`, which stays 1 until reset.
- R9: `mem_rdy` without `mem_req` has no effect: the debt stays 0 and the pulse pattern is the free-running one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fabric clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_req | input | 1 | Memory access pending |
| mem_rdy | input | 1 | Requested data is available |
| ce | output | 1 | Virtual clock enable pulse, one fabric cycle wide |
| debt | output | DEBT_W | Fabric cycles still owed to the virtual timeline |
| debt_ovf | output | 1 | Sticky flag: stall cycles were dropped at saturation |

## Verification
The bench keeps NUM=8, DEN=100 and MIN_GAP=2, which gives BOOST=5. Catch-up cycles therefore advance six steps at a time and bring pulses down to the two-cycle floor. It lowers `DEBT_MAX` to 40, so a single 60-cycle stall drives the counter into saturation and sets the sticky flag within a short run. The same run also covers full repayment afterwards and stall patterns that start while a catch-up is still in progress.

// File: rtl/vclk_ce_gen.sv
module vclk_ce_gen #(
  parameter int unsigned NUM      = 8,
  parameter int unsigned DEN      = 100,
  parameter int unsigned MIN_GAP  = 2,
  parameter int unsigned DEBT_MAX = 255,
  localparam int unsigned DEBT_W  = $clog2(DEBT_MAX + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mem_req,
  input  logic              mem_rdy,
  output logic              ce,
  output logic [DEBT_W-1:0] debt,
  output logic              debt_ovf
);

  localparam int unsigned BOOST = DEN / (NUM * MIN_GAP) - 1;
  localparam int unsigned ACC_W = $clog2(2 * DEN) + 1;
  localparam int unsigned GAP_W = $clog2(MIN_GAP + 1);

  logic [ACC_W-1:0]  acc;
  logic [ACC_W-1:0]  nxt;
  logic [DEBT_W-1:0] repay;

  wire stall  = mem_req & ~mem_rdy;
  wire at_max = (debt == DEBT_W'(DEBT_MAX));

  assign repay = (32'(debt) > BOOST) ? DEBT_W'(BOOST) : debt;
  assign nxt   = acc + ACC_W'(NUM * (32'(repay) + 1));

  wire wrap = !stall && (nxt >= ACC_W'(DEN));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc      <= '0;
      debt     <= '0;
      debt_ovf <= 1'b0;
      ce       <= 1'b0;
    end else begin
      ce <= wrap;
      if (stall) begin
        if (at_max) debt_ovf <= 1'b1;
        else        debt     <= debt + 1'b1;
      end else begin
        debt <= debt - repay;
        acc  <= wrap ? nxt - ACC_W'(DEN) : nxt;
      end
    end
  end

  logic [GAP_W-1:0] gap;
  always_ff @(posedge clk) begin
    if (!rst_n)                      gap <= GAP_W'(MIN_GAP);
    else if (ce)                     gap <= '0;
    else if (gap != GAP_W'(MIN_GAP)) gap <= gap + 1'b1;
  end

  assert_stall_holds_ce_R4: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> !ce);
  assert_debt_grows_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (stall && !at_max) |=> debt == $past(debt) + 1'b1);
  assert_repay_shrinks_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && debt != '0) |=> debt < $past(debt));
  assert_no_stall_no_debt_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && debt == '0) |=> debt == '0);
  assert_min_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ce |-> 32'(gap) >= MIN_GAP - 1);
  assert_ovf_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    debt_ovf |=> debt_ovf);
  assert_ovf_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(debt_ovf) |-> $past(stall) && $past(at_max));
  assert_debt_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    32'(debt) <= DEBT_MAX);

endmodule

// File: tb/vclk_ce_gen_test.sv
`timescale 1ns/1ps
module vclk_ce_gen_test;
  localparam int NUM = 8, DEN = 100, MIN_GAP = 2, DEBT_MAX = 40;
  localparam int BOOST = DEN / (NUM * MIN_GAP) - 1;
  localparam int DW = $clog2(DEBT_MAX + 1);

  logic clk = 1'b0, rst_n = 1'b0, mem_req = 1'b0, mem_rdy = 1'b0;
  logic ce, debt_ovf;
  logic [DW-1:0] debt;

  vclk_ce_gen #(.NUM(NUM), .DEN(DEN), .MIN_GAP(MIN_GAP), .DEBT_MAX(DEBT_MAX)) uut (
    .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_rdy(mem_rdy),
    .ce(ce), .debt(debt), .debt_ovf(debt_ovf));

  always #2.5 clk = ~clk;

  typedef struct { logic ce; int debt; logic ovf; string tag; } exp_t;
  exp_t q[$];
  int tests = 0, fails = 0, cyc = 0, first_ce = 0, ce_count = 0, last_ce = -100;
  int m_acc = 0, m_debt = 0;
  logic m_ovf = 1'b0;
  bit done = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input logic req, input logic rdy, input string tag);
    exp_t e;
    int rp, nx;
    bit w;
    mem_req = req; mem_rdy = rdy;
    w = 0;
    if (req && !rdy) begin
      if (m_debt == DEBT_MAX) m_ovf = 1'b1; else m_debt++;
    end else begin
      rp = (m_debt > BOOST) ? BOOST : m_debt;
      m_debt -= rp;
      nx = m_acc + NUM * (1 + rp);
      w = (nx >= DEN);
      m_acc = w ? nx - DEN : nx;
    end
    e.ce = w; e.debt = m_debt; e.ovf = m_ovf; e.tag = tag;
    q.push_back(e);
    @(negedge clk);
  endtask

  task automatic drain();
    while (q.size() != 0) @(negedge clk);
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(posedge clk); #1;
      if (q.size() != 0) begin
        e = q.pop_front();
        cyc++;
        check(ce === e.ce, {e.tag, " ce"}, ce, e.ce);
        check(debt === DW'(e.debt), {e.tag, " debt"}, debt, e.debt);
        check(debt_ovf === e.ovf, {e.tag, " debt_ovf"}, debt_ovf, e.ovf);
        if (ce === 1'b1) begin
          if (first_ce == 0) first_ce = cyc;
          check(cyc - last_ce >= MIN_GAP, "R7 pulse spacing", cyc - last_ce, MIN_GAP);
          last_ce = cyc;
          ce_count++;
        end
      end
    end
  end

  initial begin : watchdog
    #(5 * 20000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin : driver
    repeat (4) @(negedge clk);
    check(ce === 1'b0 && debt === '0 && debt_ovf === 1'b0, "R1 reset state", ce, 0);
    rst_n = 1'b1;
    for (int i = 0; i < 200; i++) step(1'b0, 1'b0, "R3 free run");
    drain();
    check(first_ce == 13, "R2 first pulse cycle", first_ce, 13);
    check(ce_count == 16, "R3 pulses in 200 cycles", ce_count, 16);
    for (int i = 0; i < 10; i++) step(1'b1, 1'b0, "R4 stall");
    step(1'b1, 1'b1, "R5 data ready");
    for (int i = 0; i < 60; i++) step(1'b0, 1'b0, "R6 catch-up");
    drain();
    check(debt === '0, "R6 debt repaid", debt, 0);
    for (int i = 0; i < 30; i++) step(1'b0, 1'b1, "R9 ready alone");
    drain();
    check(debt === '0, "R9 debt untouched", debt, 0);
    for (int i = 0; i < 60; i++) step(1'b1, 1'b0, "R8 saturate");
    step(1'b1, 1'b1, "R5 data ready");
    drain();
    check(debt_ovf === 1'b1, "R8 overflow set", debt_ovf, 1);
    for (int i = 0; i < 80; i++) step(1'b0, 1'b0, "R8 sticky repay");
    drain();
    check(debt_ovf === 1'b1, "R8 overflow sticky", debt_ovf, 1);
    check(debt === '0, "R6 debt repaid after saturation", debt, 0);
    for (int i = 0; i < 300; i++)
      step((i % 7) < 3, (i % 7) == 2, "R6 mixed stalls");
    for (int i = 0; i < 40; i++) step(1'b0, 1'b0, "R6 settle");
    drain();
    rst_n = 1'b0;
    @(negedge clk);
    check(ce === 1'b0 && debt === '0 && debt_ovf === 1'b0, "R1 reset clears", debt_ovf, 0);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule